// File: doc/BRIEF.md
# Oscillator Warm-Up Timer Controller

This block makes the rest of the system wait until a restarting oscillator has settled. It does this in three cases: after power-on, after the CPU leaves STOP, and when software starts a warm-up by hand. Each clock source arrives as a one-cycle tick enable in the single system clock domain. A prescaler divides the chosen source by 1, 2, 4 or 8 and feeds a 14-bit counter. The warm-up ends when the counter's upper eight bits reach a programmable compare value.

After power-on the counter always runs from the high-frequency source. The CPU and peripherals are kept in reset until the match. When STOP is released, the counter runs from whichever clock was driving the system when STOP was entered, and execution resumes without any reset. If STOP interrupts a warm-up that software started, the counter freezes and later carries on from the frozen value.

Top module: `osc_warmup_ctrl`

## Requirements
- R1: After reset, `hold_rst` is 1 and `wu_busy` and `wu_done` are 0. The settings reset to: high-frequency source (`cfg_src_lf`=0), divide code 3, and compare value 0x66. A power-on warm-up with these defaults therefore lasts 0x66 × 512 high-frequency ticks.
- R2: For a nonzero compare value C and divide code D (00→/1, 01→/2, 10→/4, 11→/8), a warm-up lasts exactly C × 2^(6+D) ticks of the selected source. The last of those ticks is sampled on the edge that raises `wu_done`.
- R3: A compare value of 0 ends the warm-up on the first counter-input tick, which is 2^D source ticks.
- R4: A `por_release` pulse starts a warm-up that counts only `hf_tick`, whatever `cfg_src_lf` says. `hold_rst` stays 1 throughout and falls in the same cycle that `wu_done` rises. Only this path ever changes `hold_rst`.
- R5: A `stop_release` pulse, given after `stop_enter` from idle, starts a cleared warm-up. This warm-up counts `lf_tick` if `sys_on_lf` was 1 at the `stop_enter` pulse, and `hf_tick` otherwise, regardless of `cfg_src_lf`. `hold_rst` stays 0.
- R6: A `stop_enter` pulse during a software-started warm-up freezes it. While frozen, ticks have no effect, `wu_done` stays 0 and `wu_busy` stays 1. After `stop_release`, counting resumes from the frozen value, so only the remaining ticks are needed.
- R7: `wu_done` is a one-cycle pulse. `wu_busy` is 1 from the cycle after a start event up to the match, and 0 in the cycle where `wu_done` is 1.
- R8: Ticks of the source that is not selected never advance the warm-up.
- R9: A `sw_start` pulse while idle starts a cleared warm-up on the source chosen by `cfg_src_lf` (0 = high frequency, 1 = low frequency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hf_tick | input | 1 | High-frequency source tick enable |
| lf_tick | input | 1 | Low-frequency source tick enable |
| cfg_we | input | 1 | Write strobe for the source and divide settings |
| cfg_src_lf | input | 1 | Source select written by cfg_we (1 = low frequency) |
| cfg_div | input | 2 | Divide code written by cfg_we |
| cmp_we | input | 1 | Write strobe for the compare value |
| cmp_val | input | 8 | Compare value written by cmp_we |
| por_release | input | 1 | Power-on release event pulse |
| sw_start | input | 1 | Software warm-up start pulse |
| stop_enter | input | 1 | STOP entry event pulse |
| stop_release | input | 1 | STOP release event pulse |
| sys_on_lf | input | 1 | 1 when the system clock comes from the low-frequency source |
| hold_rst | output | 1 | Reset hold for CPU and peripherals |
| wu_done | output | 1 | One-cycle warm-up completion pulse |
| wu_busy | output | 1 | Warm-up in progress |

## Verification
On every cycle, the assertions check four things. `wu_done` is a single-cycle pulse that coincides with `wu_busy` low. `hold_rst` only ever falls, and only together with `wu_done`. The counter does not move while it is neither running nor being cleared. The prescaler never emits a counter tick without a source tick. The exact warm-up length for each divide code and compare value is shown only by the bench scenarios. The same holds for the choice of source on the power-on and STOP paths, the rejection of the other source's ticks, and the shortened warm-up after a freeze.

// File: rtl/wu_pkg.sv
// Shared types and reset values for the oscillator warm-up timer.
// Assumes a single system clock domain; sources arrive as tick enables.
package wu_pkg;
    typedef enum logic [2:0] {
        ST_PORWAIT,  // held in reset, waiting for power-on release
        ST_POR,      // power-on warm-up, high-frequency source forced
        ST_IDLE,     // no warm-up running
        ST_SW,       // software-started warm-up
        ST_STOP,     // STOP entered from idle
        ST_FROZEN,   // STOP entered during a software warm-up
        ST_WAKE      // STOP-release warm-up
    } wu_state_e;

    localparam int unsigned WU_CNT_W   = 14;
    localparam int unsigned WU_CMP_W   = 8;
    localparam int unsigned WU_DIV_W   = 2;
    localparam logic [7:0]  WU_CMP_RST = 8'h66;
endpackage

// File: rtl/wu_cfg_regs.sv
// Holds the source select, divide code and compare value.
// Assumes writes are single-cycle strobes; reset loads the defaults.
module wu_cfg_regs #(
    parameter int unsigned DIV_W   = 2,
    parameter int unsigned CMP_W   = 8,
    parameter logic [CMP_W-1:0] CMP_RST = 8'h66
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_src_lf,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_val,
    output logic             src_lf_q,
    output logic [DIV_W-1:0] div_q,
    output logic [CMP_W-1:0] cmp_q
);
    // Source select and divide code register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_lf_q <= 1'b0;
            div_q    <= '1;
        end else if (cfg_we) begin
            src_lf_q <= cfg_src_lf;
            div_q    <= cfg_div;
        end
    end

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= CMP_RST;
        else if (cmp_we) cmp_q <= cmp_val;
    end
endmodule

// File: rtl/wu_prescaler.sv
// Divides the selected source tick by 2^div and emits counter-input ticks.
// Assumes clr and run come from the controller; clr wins over run.
module wu_prescaler #(
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic             src_tick,
    input  logic [DIV_W-1:0] div,
    output logic             out_tick
);
    localparam int unsigned PRE_W = (1 << DIV_W) - 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] mask;

    // Low 'div' bits all set marks the last source tick of a period.
    always_comb begin
        mask     = (PRE_W'(1) << div) - PRE_W'(1);
        out_tick = run && src_tick && ((pre_q & mask) == mask);
    end

    // Free-running source tick count, cleared at each warm-up start.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)         pre_q <= '0;
        else if (run && src_tick)  pre_q <= pre_q + PRE_W'(1);
    end

    a_r2_tick_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> (src_tick && run));
endmodule

// File: rtl/wu_counter.sv
// Warm-up counter: counts input ticks and flags when the upper bits reach
// the compare value. A compare of zero matches on the first tick.
module wu_counter #(
    parameter int unsigned CNT_W = 14,
    parameter int unsigned CMP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CMP_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt_q,
    output logic             match
);
    localparam int unsigned LSB = CNT_W - CMP_W;

    logic [CNT_W-1:0] cnt_nxt;

    // Match is judged on the value the current tick produces.
    always_comb begin
        cnt_nxt = cnt_q + CNT_W'(1);
        match   = tick && ((cnt_nxt[CNT_W-1:LSB] == cmp) || (cmp == '0));
    end

    // Counter register; holds whenever no tick arrives.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt_q <= '0;
        else if (tick)     cnt_q <= cnt_nxt;
    end
endmodule

// File: rtl/wu_ctrl.sv
// Sequencer for power-on, software and STOP-release warm-ups.
// Assumes event inputs are single-cycle pulses; match wins over stop_enter.
module wu_ctrl
    import wu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic por_release,
    input  logic sw_start,
    input  logic stop_enter,
    input  logic stop_release,
    input  logic sys_on_lf,
    input  logic cfg_src_lf,
    input  logic hf_tick,
    input  logic lf_tick,
    input  logic match,
    output logic clr,
    output logic run,
    output logic src_tick,
    output logic hold_rst,
    output logic done,
    output logic busy
);
    wu_state_e state_q, state_d;
    logic      stop_lf_q;

    // Next-state logic and start (clear) detection.
    always_comb begin
        state_d = state_q;
        clr     = 1'b0;
        unique case (state_q)
            ST_PORWAIT: if (por_release) begin state_d = ST_POR; clr = 1'b1; end
            ST_POR:     if (match) state_d = ST_IDLE;
            ST_IDLE: begin
                if (stop_enter)    state_d = ST_STOP;
                else if (sw_start) begin state_d = ST_SW; clr = 1'b1; end
            end
            ST_SW: begin
                if (match)           state_d = ST_IDLE;
                else if (stop_enter) state_d = ST_FROZEN;
            end
            ST_STOP:    if (stop_release) begin state_d = ST_WAKE; clr = 1'b1; end
            ST_FROZEN:  if (stop_release) state_d = ST_WAKE;
            ST_WAKE:    if (match) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Source selection per warm-up path and the running/busy indications.
    always_comb begin
        run  = (state_q == ST_POR) || (state_q == ST_SW) || (state_q == ST_WAKE);
        busy = run || (state_q == ST_FROZEN);
        unique case (state_q)
            ST_SW:   src_tick = cfg_src_lf ? lf_tick : hf_tick;
            ST_WAKE: src_tick = stop_lf_q  ? lf_tick : hf_tick;
            default: src_tick = hf_tick;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PORWAIT;
        else        state_q <= state_d;
    end

    // Capture which clock drove the system at STOP entry.
    always_ff @(posedge clk) begin
        if (!rst_n)          stop_lf_q <= 1'b0;
        else if (stop_enter && (state_q == ST_IDLE || state_q == ST_SW))
                             stop_lf_q <= sys_on_lf;
    end

    // Reset hold released only by the power-on match; done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_rst <= 1'b1;
            done     <= 1'b0;
        end else begin
            done <= match && run;
            if (state_q == ST_POR && match) hold_rst <= 1'b0;
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    a_r7_busy_starts_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(clr));
    a_r4_hold_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_rst) |-> done);
    a_r4_hold_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(hold_rst));
endmodule

// File: rtl/osc_warmup_ctrl.sv
// Top level of the oscillator warm-up timer: settings, sequencer,
// prescaler and 14-stage counter. Single clock, synchronous active-low reset.
module osc_warmup_ctrl
    import wu_pkg::*;
#(
    parameter int unsigned CNT_W = WU_CNT_W,
    parameter int unsigned CMP_W = WU_CMP_W,
    parameter int unsigned DIV_W = WU_DIV_W,
    parameter logic [CMP_W-1:0] CMP_RST = WU_CMP_RST
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hf_tick,
    input  logic             lf_tick,
    input  logic             cfg_we,
    input  logic             cfg_src_lf,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cmp_we,
    input  logic [CMP_W-1:0] cmp_val,
    input  logic             por_release,
    input  logic             sw_start,
    input  logic             stop_enter,
    input  logic             stop_release,
    input  logic             sys_on_lf,
    output logic             hold_rst,
    output logic             wu_done,
    output logic             wu_busy
);
    logic             src_lf_q;
    logic [DIV_W-1:0] div_q;
    logic [CMP_W-1:0] cmp_q;
    logic             clr, run, src_tick, cnt_tick, match;
    logic [CNT_W-1:0] cnt_q;

    wu_cfg_regs #(.DIV_W(DIV_W), .CMP_W(CMP_W), .CMP_RST(CMP_RST)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src_lf(cfg_src_lf),
        .cfg_div(cfg_div), .cmp_we(cmp_we), .cmp_val(cmp_val),
        .src_lf_q(src_lf_q), .div_q(div_q), .cmp_q(cmp_q)
    );

    wu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .por_release(por_release), .sw_start(sw_start),
        .stop_enter(stop_enter), .stop_release(stop_release), .sys_on_lf(sys_on_lf),
        .cfg_src_lf(src_lf_q), .hf_tick(hf_tick), .lf_tick(lf_tick), .match(match),
        .clr(clr), .run(run), .src_tick(src_tick), .hold_rst(hold_rst),
        .done(wu_done), .busy(wu_busy)
    );

    wu_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .src_tick(src_tick),
        .div(div_q), .out_tick(cnt_tick)
    );

    wu_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(cnt_tick), .cmp(cmp_q),
        .cnt_q(cnt_q), .match(match)
    );

    a_r6_count_frozen_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q));
endmodule

// File: tb/osc_warmup_ctrl_test.sv
// Self-checking bench: sweeps divide codes, small compare values and
// sources; computes each expected warm-up length arithmetically.
module osc_warmup_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hf_tick = 0, lf_tick = 0, cfg_we = 0, cfg_src_lf = 0;
    logic [1:0] cfg_div = 0;
    logic       cmp_we = 0;
    logic [7:0] cmp_val = 0;
    logic       por_release = 0, sw_start = 0, stop_enter = 0, stop_release = 0;
    logic       sys_on_lf = 0;
    logic       hold_rst, wu_done, wu_busy;

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    osc_warmup_ctrl uut (.*);

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        sig = 1'b1;
        @(negedge clk);
        sig = 1'b0;
    endtask

    task automatic set_cfg(input bit src, input int div, input int cmp);
        cfg_src_lf = src; cfg_div = 2'(div); cmp_val = 8'(cmp);
        cfg_we = 1; cmp_we = 1;
        @(negedge clk);
        cfg_we = 0; cmp_we = 0;
    endtask

    // Drive both sources with different periods; count ticks of the source
    // that should be counted until wu_done appears.
    task automatic run_wu(input bit sel_lf, input int hp, input int lp,
                          input int exp_ticks, input bit exp_hold, input string req);
        int  n = 0;
        bit  bad_busy = 0, bad_hold = 0;
        forever begin
            hf_tick = (cyc % hp) == 0;
            lf_tick = (cyc % lp) == 0;
            cyc++;
            if (sel_lf ? lf_tick : hf_tick) n++;
            @(negedge clk);
            if (wu_done) break;
            if (!wu_busy) bad_busy = 1;
            if (hold_rst !== exp_hold) bad_hold = 1;
            if (n > exp_ticks + 4) break;
        end
        hf_tick = 0; lf_tick = 0;
        check(n == exp_ticks && wu_done, req, n, exp_ticks);
        check(!bad_busy && !bad_hold, {req, " R7 busy/hold during run"}, int'(bad_busy), 0);
        check(!wu_busy && hold_rst == 1'b0, {req, " R7 state at done"}, int'(wu_busy), 0);
        @(negedge clk);
        check(!wu_done, {req, " R7 done one cycle"}, int'(wu_done), 0);
    endtask

    function automatic int exp_len(input int cmp, input int div);
        return (cmp == 0) ? (1 << div) : cmp * 64 * (1 << div);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check(hold_rst && !wu_busy && !wu_done, "R1 reset outputs", int'(hold_rst), 1);
        rst_n = 1;
        @(negedge clk);
        // Power-on with low-frequency source selected: must still count hf (R4, R8).
        set_cfg(1, 0, 1);
        check(hold_rst === 1'b1, "R4 hold before release", int'(hold_rst), 1);
        pulse(por_release);
        run_wu(0, 3, 1, 64, 1, "R4 por counts hf");

        // Default settings after a fresh reset (R1).
        rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
        @(negedge clk);
        pulse(por_release);
        run_wu(0, 1, 2, 8'h66 * 512, 1, "R1 default por length");

        // Software sweep: source, divide code, compare value (R2, R3, R8, R9).
        for (int s = 0; s < 2; s++)
            for (int d = 0; d < 4; d++)
                for (int c = 0; c < 4; c++) begin
                    set_cfg(s[0], d, c);
                    pulse(sw_start);
                    run_wu(s[0], 2, 3, exp_len(c, d), 0,
                           c == 0 ? "R3 zero compare" : "R2 R9 sw length");
                end

        // STOP release from idle: source is the clock latched at entry (R5).
        for (int l = 0; l < 2; l++)
            for (int d = 0; d < 4; d++) begin
                set_cfg(!l[0], d, 2);
                sys_on_lf = l[0];
                pulse(stop_enter);
                sys_on_lf = ~l[0];
                hf_tick = 1; lf_tick = 1;
                repeat (20) @(negedge clk);
                hf_tick = 0; lf_tick = 0;
                check(!wu_busy && !wu_done && !hold_rst, "R5 stopped idle", int'(wu_busy), 0);
                pulse(stop_release);
                run_wu(l[0], 2, 3, exp_len(2, d), 0, "R5 wake source");
            end

        // Freeze during software warm-up and resume (R6).
        begin
            bit bad = 0;
            set_cfg(0, 0, 2);
            pulse(sw_start);
            for (int i = 0; i < 50; i++) begin
                hf_tick = 1;
                @(negedge clk);
                if (wu_done) bad = 1;
            end
            hf_tick = 0;
            sys_on_lf = 0;
            pulse(stop_enter);
            hf_tick = 1; lf_tick = 1;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (wu_done || !wu_busy) bad = 1;
            end
            hf_tick = 0; lf_tick = 0;
            check(!bad, "R6 frozen holds", int'(bad), 0);
            pulse(stop_release);
            run_wu(0, 1, 1, 128 - 50, 0, "R6 resume remaining");
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule